// File: doc/BRIEF.md
# Flag-Gated Interrupt Request Logic

This block gathers three single-cycle event pulses (a periodic tick, an alarm match and an end-of-update event) and turns them into one active-low, open-drain interrupt request. Each event sets a sticky status flag of its own. Each source also has an enable bit. The request pin is pulled low while at least one flag is set together with its enable. The open-drain pin is modelled as an output-enable signal: when `irq_oe_o` is 1, the pin is driven low.

The host has two plain register ports. It writes the three enable bits through a control port and can read them back at any time. It reads the flags through a status port. Every status read returns a snapshot of the flags and the summary bit, and the same read clears all flags. Flags always record their events, even when the matching enable is 0. The host can therefore poll the sources without taking interrupts. Only host writes change the enable bits; neither events nor reads touch them.

Top module: `irq_flag_gate`

## Requirements
- R1: After reset, every flag is 0, the enables read back as 3'b000, `irq_oe_o` is 0 and `sts_rd_data_o` is 8'h00.
- R2: A 1 on an event input at a rising edge sets that source's flag at that edge. This happens whatever the enable value, including the periodic flag when its enable is 0.
- R3: `irq_oe_o` equals (periodic flag AND periodic enable) OR (alarm flag AND alarm enable) OR (update flag AND update enable). It is evaluated from the registered flags and enables, so it is valid right after the edge that changes either of them.
- R4: Once asserted, `irq_oe_o` stays 1 until a status read clears the flags or a control write drops the enables. There is no self-clearing.
- R5: Status word layout: bit 7 is the summary (the R3 value), bit 6 is periodic, bit 5 is alarm, bit 4 is update, and bits 3:0 read 0. The word is captured at the edge where `sts_rd_en_i` is 1, shows on `sts_rd_data_o` after that edge, and holds until the next read.
- R6: A status read clears all flags at the same edge, and the returned word shows the values from before the clear.
- R7: An event that arrives in the same cycle as a status read leaves its flag set after the read. That event does not appear in the word returned by that read.
- R8: The enables change only at an edge where `ctl_wr_en_i` is 1, taking `ctl_wr_data_i`: bit 2 is the periodic enable, bit 1 is alarm, bit 0 is update. `ctl_rd_data_o` shows them in the same layout.
- R9: The flags are read-only: a control write does not set or clear any flag.
- R10: Clearing an enable while its flag is set drops the request and keeps the flag. Setting the enable again raises the request with no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tick_i | input | 1 | Periodic tick event pulse |
| ev_alarm_i | input | 1 | Alarm match event pulse |
| ev_update_i | input | 1 | End-of-update event pulse |
| ctl_wr_en_i | input | 1 | Write strobe for the enable bits |
| ctl_wr_data_i | input | 3 | New enables {periodic, alarm, update} |
| ctl_rd_data_o | output | 3 | Current enables {periodic, alarm, update} |
| sts_rd_en_i | input | 1 | Status read strobe (read clears the flags) |
| sts_rd_data_o | output | 8 | Last status word captured |
| irq_oe_o | output | 1 | 1 = pull the interrupt pin low |

## Verification
Every result of this block is due one edge after the stimulus that causes it:
- a flag, and any request it raises, appears after the edge that samples the event;
- a new enable value and its effect on `irq_oe_o` appear after the write edge;
- the status word and the clear both appear after the read edge.

The bench changes inputs 1 ns after a rising edge and samples outputs 1 ns after the next one, so every check falls exactly one register stage after its cause. Hold checks repeat the sample over several idle cycles. The checks that tie a flag to an event and a read to its clear look one cycle back.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_SRC = 3;
  localparam int unsigned STS_W_DEF = 8;

  typedef enum logic [1:0] {
    SRC_UPDATE   = 2'd0,
    SRC_ALARM    = 2'd1,
    SRC_PERIODIC = 2'd2
  } src_e;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // A set in the same cycle as a clear wins, so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= wr_data_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_status_fmt.sv
module irq_status_fmt #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         summary_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned PAD = W - 1 - N;

  assign summary_o = |(flags_i & en_i);

  generate
    if (PAD > 0) begin : g_pad
      assign word_o = {summary_o, flags_i, {PAD{1'b0}}};
    end else begin : g_nopad
      assign word_o = {summary_o, flags_i};
    end
  endgenerate
endmodule

// File: rtl/irq_flag_gate.sv
module irq_flag_gate #(
  parameter int unsigned STS_W = irq_pkg::STS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tick_i,
  input  logic             ev_alarm_i,
  input  logic             ev_update_i,
  input  logic             ctl_wr_en_i,
  input  logic [2:0]       ctl_wr_data_i,
  output logic [2:0]       ctl_rd_data_o,
  input  logic             sts_rd_en_i,
  output logic [STS_W-1:0] sts_rd_data_o,
  output logic             irq_oe_o
);
  import irq_pkg::*;
  localparam int unsigned NS = N_SRC;

  logic [NS-1:0]    ev_vec;
  logic [NS-1:0]    flag_q;
  logic [NS-1:0]    en_q;
  logic             summary;
  logic [STS_W-1:0] word;
  logic [STS_W-1:0] rd_q;

  always_comb begin
    ev_vec               = '0;
    ev_vec[SRC_PERIODIC] = ev_tick_i;
    ev_vec[SRC_ALARM]    = ev_alarm_i;
    ev_vec[SRC_UPDATE]   = ev_update_i;
  end

  generate
    for (genvar i = 0; i < NS; i++) begin : g_flag
      irq_flag_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_vec[i]),
        .clr_i  (sts_rd_en_i),
        .flag_o (flag_q[i])
      );
    end
  endgenerate

  irq_enable_reg #(.W(NS)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (ctl_wr_en_i),
    .wr_data_i (ctl_wr_data_i),
    .en_o      (en_q)
  );

  irq_status_fmt #(.N(NS), .W(STS_W)) u_fmt (
    .flags_i   (flag_q),
    .en_i      (en_q),
    .summary_o (summary),
    .word_o    (word)
  );

  // Snapshot taken from the pre-clear flags on the read edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_q <= '0;
    else if (sts_rd_en_i) rd_q <= word;
  end

  assign ctl_rd_data_o = en_q;
  assign sts_rd_data_o = rd_q;
  assign irq_oe_o      = summary;
endmodule

// File: rtl/irq_flag_gate_chk.sv
module irq_flag_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ev,
  input logic [2:0] flags,
  input logic       ctl_wr_en,
  input logic [2:0] ctl_wr_data,
  input logic [2:0] ctl_rd_data,
  input logic       sts_rd_en,
  input logic [7:0] sts_rd_data,
  input logic       irq_oe
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 3'b000) |=> ((flags & $past(ev)) == $past(ev)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe && !sts_rd_en && !ctl_wr_en) |=> irq_oe);

  p_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd_en |=> (sts_rd_data[3:0] == 4'h0 && sts_rd_data[6:4] == $past(flags)
                   && sts_rd_data[7] == $past(irq_oe)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd_en |=> (flags == $past(ev)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd_en |=> ((flags & $past(flags)) == $past(flags)));

  p_en_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_rd_data));

  p_en_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> (ctl_rd_data == $past(ctl_wr_data)));
endmodule

bind irq_flag_gate irq_flag_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev          ({ev_tick_i, ev_alarm_i, ev_update_i}),
  .flags       (flag_q),
  .ctl_wr_en   (ctl_wr_en_i),
  .ctl_wr_data (ctl_wr_data_i),
  .ctl_rd_data (ctl_rd_data_o),
  .sts_rd_en   (sts_rd_en_i),
  .sts_rd_data (sts_rd_data_o),
  .irq_oe      (irq_oe_o)
);

// File: tb/irq_flag_gate_tb.sv
`timescale 1ns/1ps
module irq_flag_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_tick = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [2:0] ctl_wr_data = 3'b000;
  logic [2:0] ctl_rd_data;
  logic       sts_rd_en = 1'b0;
  logic [7:0] sts_rd_data;
  logic       irq_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_flag_gate u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_tick_i     (ev_tick),
    .ev_alarm_i    (ev_alarm),
    .ev_update_i   (ev_update),
    .ctl_wr_en_i   (ctl_wr_en),
    .ctl_wr_data_i (ctl_wr_data),
    .ctl_rd_data_o (ctl_rd_data),
    .sts_rd_en_i   (sts_rd_en),
    .sts_rd_data_o (sts_rd_data),
    .irq_oe_o      (irq_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic [2:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    step();
    ctl_wr_en = 1'b0; ctl_wr_data = 3'b000;
  endtask

  task automatic pulse(input logic t, input logic a, input logic u);
    ev_tick = t; ev_alarm = a; ev_update = u;
    step();
    ev_tick = 1'b0; ev_alarm = 1'b0; ev_update = 1'b0;
  endtask

  task automatic rd_sts(output logic [7:0] d);
    sts_rd_en = 1'b1;
    step();
    sts_rd_en = 1'b0;
    d = sts_rd_data;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, irq_oe}, 8'h00);
    chk("R1 enables", {5'd0, ctl_rd_data}, 8'h00);
    chk("R1 status", sts_rd_data, 8'h00);
  endtask

  task automatic t_poll_disabled();
    logic [7:0] d;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2 r3_ no irq when disabled", {7'd0, irq_oe}, 8'h00);
    rd_sts(d);
    chk("R2 periodic flag set while disabled", d, 8'h40);
    repeat (3) step();
    chk("R5 status held", sts_rd_data, 8'h40);
    rd_sts(d);
    chk("R6 flags cleared by read", d, 8'h00);
  endtask

  task automatic t_enabled_irq();
    logic [7:0] d;
    wr_en(3'b100);
    chk("R8 enable write", {5'd0, ctl_rd_data}, 8'h04);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R3 irq raised", {7'd0, irq_oe}, 8'h01);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R4 irq held", {7'd0, irq_oe}, 8'h01);
    end
    wr_en(3'b000);
    chk("R10 irq drops on disable", {7'd0, irq_oe}, 8'h00);
    wr_en(3'b100);
    chk("R10 irq back on re-enable", {7'd0, irq_oe}, 8'h01);
    rd_sts(d);
    chk("R5 R6 pre-clear word", d, 8'hC0);
    chk("R6 irq cleared by read", {7'd0, irq_oe}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr_en(3'b011);
    pulse(1'b0, 1'b1, 1'b1);
    chk("R3 alarm/update irq", {7'd0, irq_oe}, 8'h01);
    rd_sts(d);
    chk("R5 alarm+update layout", d, 8'hB0);
    wr_en(3'b100);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3 update not enabled", {7'd0, irq_oe}, 8'h00);
    rd_sts(d);
    chk("R5 update only, summary 0", d, 8'h10);
  endtask

  task automatic t_coincident();
    logic [7:0] d;
    wr_en(3'b000);
    pulse(1'b1, 1'b0, 1'b0);
    ev_alarm = 1'b1;
    rd_sts(d);
    ev_alarm = 1'b0;
    chk("R7 read excludes same-cycle event", d, 8'h40);
    rd_sts(d);
    chk("R7 same-cycle event kept", d, 8'h20);
  endtask

  task automatic t_enables_untouched();
    logic [7:0] d;
    wr_en(3'b101);
    pulse(1'b1, 1'b1, 1'b1);
    rd_sts(d);
    chk("R8 enables kept over events/read", {5'd0, ctl_rd_data}, 8'h05);
    pulse(1'b1, 1'b0, 1'b0);
    wr_en(3'b111);
    wr_en(3'b010);
    chk("R9 flag survives ctl write (no alarm irq)", {7'd0, irq_oe}, 8'h00);
    wr_en(3'b111);
    rd_sts(d);
    chk("R9 ctl write left flags", d, 8'hC0);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_poll_disabled();
    t_enabled_irq();
    t_layout();
    t_coincident();
    t_enables_untouched();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule